// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit sits next to a BCD calendar counter and watches its six running fields: seconds, minutes, hours, day of week, day of month and month. Each field has an alarm byte that holds a target value and a compare-enable bit. A field whose enable bit is clear is a "don't care" and never blocks a match. When every enabled field equals its running counterpart, the unit sets a sticky alarm flag. An interrupt line is raised while both that flag and a separate interrupt enable are set.

Software loads the alarm bytes through a small indexed write port. It updates the flag and the interrupt enable together through one control write. Writing 0 to the flag clears it, and writing 1 to the flag leaves it unchanged. The flag is set only on the first cycle of a match. It does not set again while the time stays equal. If no field is enabled, the unit never fires.

Top module: `alarm_comparator`

## Requirements
- R1: After reset the alarm flag, the interrupt enable and the interrupt output are 0, and every alarm byte is 0, so no field is enabled.
- R2: An alarm byte is written when `alm_wr` is 1. The byte goes to the field selected by `alm_idx`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month. Bit 7 of the byte is the compare enable for that field and bits 6:0 are the BCD target.
- R3: A field whose compare enable is 0 is treated as matching, whatever its running value.
- R4: The flag becomes 1 at the clock edge that follows the first cycle in which at least one field is enabled and every enabled field matches. A field matches when its running byte in `now_bcd` (field i at bits 8i+7:8i) equals {0, target}. A mismatch in any single enabled field prevents the flag.
- R5: While the match persists, the flag is not set again after software clears it. The flag can fire again only after the match has been broken for at least one cycle.
- R6: With no field enabled, the flag never becomes 1.
- R7: `alm_irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R8: A control write (`ctl_wr` = 1) loads the interrupt enable from `ctl_ie_wd`. In the same write, `ctl_flag_wd` = 0 clears the flag and `ctl_flag_wd` = 1 leaves the flag unchanged.
- R9: If a new match arrives at the same edge as a control write that clears the flag, the flag is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_bcd | input | 48 | Running BCD fields, field i at bits 8i+7:8i |
| alm_wr | input | 1 | Alarm byte write strobe |
| alm_idx | input | 3 | Field index of the alarm byte being written |
| alm_wdata | input | 8 | Alarm byte: bit 7 enable, bits 6:0 BCD target |
| ctl_wr | input | 1 | Control write strobe |
| ctl_flag_wd | input | 1 | Flag write value (0 clears, 1 keeps) |
| ctl_ie_wd | input | 1 | Interrupt enable write value |
| alm_flag | output | 1 | Sticky alarm flag |
| alm_ie | output | 1 | Interrupt enable |
| alm_irq | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach is a fresh match landing on the same edge as a software clear of the flag. To set it up, the bench first breaks the match and clears the flag. Then, at a single falling edge, it restores the matching seconds value and issues the clearing control write. A second difficult case is clearing the flag while the match is still held, then showing that the flag stays low until the time moves away and comes back. A behavioural model of the flag and the enable runs beside the design and is compared on every cycle.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
   localparam int ALM_FIELD_W  = 8;
   localparam int ALM_N_FIELDS = 6;

   typedef enum int {
      FLD_SEC  = 0,
      FLD_MIN  = 1,
      FLD_HOUR = 2,
      FLD_WDAY = 3,
      FLD_MDAY = 4,
      FLD_MON  = 5
   } alm_field_e;
endpackage

// File: rtl/alarm_store.sv
module alarm_store #(
   parameter int FW = 8,
   parameter int NF = 6,
   parameter int IW = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IW-1:0]    idx,
   input  logic [FW-1:0]    wdata,
   output logic [NF*FW-1:0] bytes_o
);
   for (genvar f = 0; f < NF; f++) begin : g_fld
      logic [FW-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (wr && (idx == IW'(f))) begin
            byte_q <= wdata;
         end
      end
      assign bytes_o[f*FW +: FW] = byte_q;
   end
endmodule

// File: rtl/field_cmp.sv
module field_cmp #(
   parameter int FW = 8
) (
   input  logic [FW-1:0] alarm_byte,
   input  logic [FW-1:0] now_val,
   output logic          en_o,
   output logic          eq_o
);
   assign en_o = alarm_byte[FW-1];
   assign eq_o = ({1'b0, alarm_byte[FW-2:0]} == now_val);
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic ctl_wr,
   input  logic flag_wd,
   input  logic ie_wd,
   output logic flag_o,
   output logic ie_o,
   output logic irq_o,
   output logic hit_q_o
);
   logic hit_q, flag_q, ie_q;
   logic fresh;

   assign fresh = hit && !hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         flag_q <= 1'b0;
         ie_q   <= 1'b0;
      end else begin
         hit_q <= hit;
         if (fresh) begin
            flag_q <= 1'b1;
         end else if (ctl_wr && !flag_wd) begin
            flag_q <= 1'b0;
         end
         if (ctl_wr) begin
            ie_q <= ie_wd;
         end
      end
   end

   assign flag_o  = flag_q;
   assign ie_o    = ie_q;
   assign irq_o   = flag_q & ie_q;
   assign hit_q_o = hit_q;
endmodule

// File: rtl/alarm_comparator.sv
module alarm_comparator
   import alarm_cmp_pkg::*;
#(
   parameter  int FIELD_W  = ALM_FIELD_W,
   parameter  int N_FIELDS = ALM_N_FIELDS,
   localparam int IDX_W    = (N_FIELDS > 1) ? $clog2(N_FIELDS) : 1,
   localparam int BUS_W    = FIELD_W * N_FIELDS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BUS_W-1:0]   now_bcd,
   input  logic               alm_wr,
   input  logic [IDX_W-1:0]   alm_idx,
   input  logic [FIELD_W-1:0] alm_wdata,
   input  logic               ctl_wr,
   input  logic               ctl_flag_wd,
   input  logic               ctl_ie_wd,
   output logic               alm_flag,
   output logic               alm_ie,
   output logic               alm_irq
);
   if (FIELD_W < 2) begin : g_bad_width
      $error("alarm_comparator: FIELD_W must be at least 2");
   end
   if (N_FIELDS < 1) begin : g_bad_count
      $error("alarm_comparator: N_FIELDS must be at least 1");
   end

   logic [BUS_W-1:0]    alarm_bytes;
   logic [N_FIELDS-1:0] en_vec;
   logic [N_FIELDS-1:0] eq_vec;
   logic                hit;
   logic                hit_q;

   alarm_store #(.FW(FIELD_W), .NF(N_FIELDS), .IW(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (alm_wr),
      .idx     (alm_idx),
      .wdata   (alm_wdata),
      .bytes_o (alarm_bytes)
   );

   for (genvar f = 0; f < N_FIELDS; f++) begin : g_cmp
      field_cmp #(.FW(FIELD_W)) u_cmp (
         .alarm_byte (alarm_bytes[f*FIELD_W +: FIELD_W]),
         .now_val    (now_bcd[f*FIELD_W +: FIELD_W]),
         .en_o       (en_vec[f]),
         .eq_o       (eq_vec[f])
      );
   end

   // a disabled field passes; at least one field must take part
   assign hit = (|en_vec) && (&(eq_vec | ~en_vec));

   flag_ctrl u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .ctl_wr  (ctl_wr),
      .flag_wd (ctl_flag_wd),
      .ie_wd   (ctl_ie_wd),
      .flag_o  (alm_flag),
      .ie_o    (alm_ie),
      .irq_o   (alm_irq),
      .hit_q_o (hit_q)
   );
endmodule

// File: rtl/alarm_comparator_chk.sv
module alarm_comparator_chk #(
   parameter int N_FIELDS = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                hit,
   input logic                hit_q,
   input logic [N_FIELDS-1:0] en_vec,
   input logic                ctl_wr,
   input logic                ctl_flag_wd,
   input logic                ctl_ie_wd,
   input logic                flag,
   input logic                ie,
   input logic                irq
);
   // R4
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(hit) && !$past(hit_q)));

   // R9
   hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !hit_q) |=> flag);

   // R6
   no_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec == '0) |-> !hit);

   // R8
   sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_flag_wd && !(hit && !hit_q)) |=> !flag);

   // R8
   ie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (ie == $past(ctl_ie_wd)));

   // R5
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !(hit && !hit_q)) |=> !flag);

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie || !flag) |-> !irq);
endmodule

bind alarm_comparator alarm_comparator_chk #(.N_FIELDS(N_FIELDS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hit         (hit),
   .hit_q       (hit_q),
   .en_vec      (en_vec),
   .ctl_wr      (ctl_wr),
   .ctl_flag_wd (ctl_flag_wd),
   .ctl_ie_wd   (ctl_ie_wd),
   .flag        (alm_flag),
   .ie          (alm_ie),
   .irq         (alm_irq)
);

// File: tb/alarm_comparator_bench.sv
`timescale 1ns/1ps
module alarm_comparator_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] now_bcd = '0;
   logic        alm_wr = 1'b0;
   logic [2:0]  alm_idx = '0;
   logic [7:0]  alm_wdata = '0;
   logic        ctl_wr = 1'b0;
   logic        ctl_flag_wd = 1'b0;
   logic        ctl_ie_wd = 1'b0;
   logic        alm_flag, alm_ie, alm_irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   alarm_comparator u_alarm_comparator (
      .clk(clk), .rst_n(rst_n), .now_bcd(now_bcd),
      .alm_wr(alm_wr), .alm_idx(alm_idx), .alm_wdata(alm_wdata),
      .ctl_wr(ctl_wr), .ctl_flag_wd(ctl_flag_wd), .ctl_ie_wd(ctl_ie_wd),
      .alm_flag(alm_flag), .alm_ie(alm_ie), .alm_irq(alm_irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference
   logic [7:0] m_al [6];
   bit m_flag, m_ie, m_prev;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int f = 0; f < 6; f++) m_al[f] = 8'h00;
         m_flag = 0; m_ie = 0; m_prev = 0;
      end else begin
         bit any, all, hit;
         any = 0; all = 1;
         for (int f = 0; f < 6; f++) begin
            if (m_al[f][7]) begin
               any = 1;
               if (now_bcd[f*8 +: 8] != {1'b0, m_al[f][6:0]}) all = 0;
            end
         end
         hit = any && all;
         if (hit && !m_prev) m_flag = 1;
         else if (ctl_wr && !ctl_flag_wd) m_flag = 0;
         if (ctl_wr) m_ie = ctl_ie_wd;
         if (alm_wr && alm_idx < 6) m_al[alm_idx] = alm_wdata;
         m_prev = hit;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 model flag", int'(alm_flag), int'(m_flag));
         chk("R8 model ie", int'(alm_ie), int'(m_ie));
         chk("R7 model irq", int'(alm_irq), int'(m_flag && m_ie));
      end
   end

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_time(input logic [7:0] s, mi, h, w, d, mo);
      now_bcd = {mo, d, w, h, mi, s};
   endtask

   task automatic wr_alarm(input int idx, input logic [7:0] data);
      alm_wr = 1'b1; alm_idx = 3'(idx); alm_wdata = data;
      step();
      alm_wr = 1'b0;
   endtask

   task automatic ctl(input bit fw, input bit iw);
      ctl_wr = 1'b1; ctl_flag_wd = fw; ctl_ie_wd = iw;
      step();
      ctl_wr = 1'b0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      set_time(8'h29, 8'h15, 8'h07, 8'h02, 8'h11, 8'h04);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 flag", int'(alm_flag), 0);
      chk("R1 ie", int'(alm_ie), 0);
      chk("R1 irq", int'(alm_irq), 0);
      step();
      chk("R1 no field enabled, flag", int'(alm_flag), 0);

      ctl(0, 1);
      chk("R8 ie loaded", int'(alm_ie), 1);
      // R2 seconds and minutes enabled, hours left disabled
      wr_alarm(0, 8'hB0);
      wr_alarm(1, 8'h95);
      wr_alarm(2, 8'h23);
      chk("R4 seconds differ, flag", int'(alm_flag), 0);
      now_bcd[7:0] = 8'h30;
      step();
      chk("R4 match sets flag", int'(alm_flag), 1);
      chk("R3 disabled hour ignored", int'(alm_flag), 1);
      chk("R7 irq on", int'(alm_irq), 1);

      // R5 clear during a held match
      ctl(0, 1);
      chk("R5 cleared", int'(alm_flag), 0);
      repeat (3) step();
      chk("R5 no re-set while held", int'(alm_flag), 0);
      now_bcd[7:0] = 8'h31;
      step();
      now_bcd[7:0] = 8'h30;
      step();
      chk("R5 re-armed after break", int'(alm_flag), 1);

      // R8 writing 1 keeps flag, R7 gated by enable
      ctl(1, 0);
      chk("R8 flag kept on write 1", int'(alm_flag), 1);
      chk("R8 ie cleared", int'(alm_ie), 0);
      chk("R7 irq off without ie", int'(alm_irq), 0);

      // R9 new match at the same edge as a clear
      now_bcd[7:0] = 8'h31;
      ctl(0, 1);
      chk("R9 setup flag low", int'(alm_flag), 0);
      now_bcd[7:0] = 8'h30;
      ctl(0, 1);
      chk("R9 hardware set wins", int'(alm_flag), 1);

      // R4 all six fields enabled, one mismatch blocks
      set_time(8'h00, 8'h10, 8'h23, 8'h06, 8'h31, 8'h11);
      wr_alarm(0, 8'h85);
      wr_alarm(1, 8'h90);
      wr_alarm(2, 8'hA3);
      wr_alarm(3, 8'h86);
      wr_alarm(4, 8'hB1);
      wr_alarm(5, 8'h92);
      ctl(0, 1);
      now_bcd[7:0] = 8'h05;
      step();
      chk("R4 month mismatch blocks", int'(alm_flag), 0);
      now_bcd[47:40] = 8'h12;
      step();
      chk("R4 six-field match", int'(alm_flag), 1);

      // R2 bit 7 clear on month turns it into a don't care
      now_bcd[7:0] = 8'h00;
      wr_alarm(5, 8'h12);
      ctl(0, 1);
      set_time(8'h05, 8'h10, 8'h23, 8'h06, 8'h31, 8'h01);
      step();
      chk("R2 month enable off, flag", int'(alm_flag), 1);

      // R6 nothing enabled
      now_bcd[7:0] = 8'h00;
      wr_alarm(0, 8'h05);
      wr_alarm(1, 8'h10);
      wr_alarm(2, 8'h23);
      wr_alarm(3, 8'h06);
      wr_alarm(4, 8'h31);
      wr_alarm(5, 8'h01);
      ctl(0, 1);
      set_time(8'h05, 8'h10, 8'h23, 8'h06, 8'h31, 8'h01);
      step();
      chk("R6 no enable, equal time", int'(alm_flag), 0);
      for (int i = 0; i < 8; i++) begin
         now_bcd[7:0] = 8'(i);
         step();
      end
      chk("R6 never fires", int'(alm_flag), 0);
      chk("R7 irq stays low", int'(alm_irq), 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule